// File: doc/BRIEF.md
# Logic analyzer command decoder

This block sits behind a UART receiver on a sampling logic analyzer and turns the received byte stream into configuration state and control strobes. A byte with its top bit clear is a one-byte command. A byte with its top bit set opens a five-byte command. The four bytes that follow it form a 32-bit argument, and the first argument byte is the least significant. Once all four argument bytes have arrived, the decoder loads one of three configuration registers:

- the sample clock divider;
- the packed capture size, which holds a read count and a delay count;
- the flag word, which holds demux, noise filter, run-length encoding and the per-group channel disables.

The one-byte commands do three things. One command fires a run strobe. Another fires a reset strobe. A third loads a fixed four-byte identification reply into a small transmit queue, which a UART transmitter drains through a valid/ready handshake.

Framing has no separate sync signal. It recovers through reset bytes: any five zero bytes in a row leave the parser waiting for an opcode, whatever point of a five-byte command it was in. Any zero bytes still needed to finish the open command are taken as its arguments. The zero bytes that follow are reset commands.

Top module: `lacmd_decoder`

## Requirements
- R1: After reset, div_value is 0, read_count and delay_count are 1, every group_en bit is 1, demux_en, filter_en and rle_en are 0, groups_on equals the group count, and tx_valid is 0.
- R2: A byte with bit 7 set starts a long command that takes exactly four more bytes as its argument, with the first argument byte in bits 7:0 and the last in bits 31:24. Every byte received while a long command is open is an argument only, including 0x00, 0x01 and 0x02, and produces no strobe and no reply.
- R3: Long opcode 0x80 loads div_value with argument bits 23:0 two cycles after the last argument byte is accepted; bits 31:24 are ignored. The sample rate is clock / (div_value + 1).
- R4: Long opcode 0x81 sets read_count to argument bits 15:0 plus one and delay_count to argument bits 31:16 plus one, with both counts in units of four samples.
- R5: Long opcode 0x82 loads the flags. Argument bit 0 is demux_en and bit 1 is filter_en. Bits 5:2 disable channel groups 0 to 3, a 1 turning the group off, so group_en is their inverse. Bit 6 is rle_en. groups_on is the number of enabled groups. All other bits are ignored.
- R6: Byte 0x01 received while no long command is open raises run_pulse for exactly the one cycle after the byte is accepted.
- R7: Byte 0x00 received while no long command is open raises reset_pulse for one cycle. After any five consecutive 0x00 bytes the parser is waiting for an opcode, so an opcode followed by k argument bytes (k from 0 to 4) and then five zeros yields k+1 reset pulses.
- R8: Byte 0x02 received while no long command is open queues the reply 0x31, 0x53, 0x4C, 0x4F in that order. tx_valid stays high and tx_data stays stable while tx_ready is low, and each cycle with both high removes one byte.
- R9: An identification request that arrives while the transmit queue is not empty is ignored.
- R10: Unknown one-byte codes and unknown long opcodes produce no strobe and change no register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| run_pulse | output | 1 | One-cycle acquisition start strobe |
| reset_pulse | output | 1 | One-cycle analyzer reset strobe |
| div_value | output | 24 | Sample clock divider |
| read_count | output | 17 | Samples to read, in units of four |
| delay_count | output | 17 | Samples after trigger, in units of four |
| demux_en | output | 1 | Double-rate demux mode |
| filter_en | output | 1 | Noise filter enable |
| rle_en | output | 1 | Run-length encoding enable |
| group_en | output | 4 | Per-group enable for the 8-bit channel groups |
| groups_on | output | 3 | Count of enabled groups |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |

## Verification
The flag command is swept over all 256 values of its low argument byte, with 0xFF in the upper bytes. This separates the flag bits from one another and from bits that must be ignored, and it confirms the group count for every disable pattern. The divider and capture-size commands each receive a sequence of computed words, including all-ones and all-zeros fields. Because every argument byte differs, a byte-order mistake or a plus-one mistake shows up in the result. The resynchronisation pattern aborts a divider command at each of its five positions and counts the reset pulses that follow, which shows whether zeros are counted as arguments or as commands. Separate sequences send run and identification codes inside an open command, send unknown codes, and send a second identification request before the first reply has drained.

// File: rtl/lacmd_pkg.sv
package lacmd_pkg;
  localparam int ARG_W  = 32;
  localparam int CNT_W  = 16;
  localparam int ID_LEN = 4;

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h02;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;

  // top bit marks an opcode that carries an argument
  function automatic logic is_long(input logic [7:0] b);
    return b[7];
  endfunction

  // identification reply, first byte sent first
  function automatic logic [7:0] id_byte(input int unsigned idx);
    case (idx)
      0:       return 8'h31;
      1:       return 8'h53;
      2:       return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction

  // counts travel as value minus one
  function automatic logic [CNT_W:0] count_of(input logic [CNT_W-1:0] f);
    return {1'b0, f} + {{CNT_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/lacmd_frame.sv
module lacmd_frame
  import lacmd_pkg::*;
#(
  parameter int ARG_BYTES = ARG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             idle,
  output logic             short_stb,
  output logic [7:0]       short_code,
  output logic             long_stb,
  output logic [7:0]       long_op,
  output logic [ARG_W-1:0] long_arg
);
  localparam int AC_W = $clog2(ARG_BYTES);

  logic             busy;
  logic [AC_W-1:0]  argc;
  logic [7:0]       op_q;
  logic [ARG_W-1:0] sh;
  logic [ARG_W-1:0] sh_next;

  assign sh_next = {in_byte, sh[ARG_W-1:8]};
  assign idle    = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      argc       <= '0;
      op_q       <= '0;
      sh         <= '0;
      short_stb  <= 1'b0;
      short_code <= '0;
      long_stb   <= 1'b0;
      long_op    <= '0;
      long_arg   <= '0;
    end else begin
      short_stb <= 1'b0;
      long_stb  <= 1'b0;
      if (in_valid) begin
        if (!busy) begin
          if (is_long(in_byte)) begin
            busy <= 1'b1;
            argc <= '0;
            op_q <= in_byte;
          end else begin
            short_stb  <= 1'b1;
            short_code <= in_byte;
          end
        end else begin
          sh   <= sh_next;
          argc <= argc + 1'b1;
          if (argc == AC_W'(ARG_BYTES - 1)) begin
            busy     <= 1'b0;
            long_stb <= 1'b1;
            long_op  <= op_q;
            long_arg <= sh_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lacmd_regs.sv
module lacmd_regs
  import lacmd_pkg::*;
#(
  parameter int DIV_W  = 24,
  parameter int GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  long_stb,
  input  logic [7:0]            long_op,
  input  logic [ARG_W-1:0]      long_arg,
  output logic [DIV_W-1:0]      div_q,
  output logic [CNT_W-1:0]      rd_field,
  output logic [CNT_W-1:0]      dl_field,
  output logic [GROUPS+2:0]     flags_q
);
  localparam int FLAG_W = GROUPS + 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      rd_field <= '0;
      dl_field <= '0;
      flags_q  <= '0;
    end else if (long_stb) begin
      case (long_op)
        OP_DIV:   div_q <= long_arg[DIV_W-1:0];
        OP_SIZE: begin
          rd_field <= long_arg[CNT_W-1:0];
          dl_field <= long_arg[2*CNT_W-1:CNT_W];
        end
        OP_FLAGS: flags_q <= long_arg[FLAG_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lacmd_reply.sv
module lacmd_reply
  import lacmd_pkg::*;
#(
  parameter int DEPTH = ID_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_QW = $clog2(DEPTH + 1);

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  rd;
  logic [CNT_QW-1:0] fill;
  logic              take;

  assign tx_valid = (fill != '0);
  assign tx_data  = mem[rd];
  assign take     = load && (fill == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)    mem[i] <= '0;
      else if (take) mem[i] <= id_byte(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd   <= '0;
      fill <= '0;
    end else if (take) begin
      rd   <= '0;
      fill <= CNT_QW'(DEPTH);
    end else if (tx_valid && tx_ready) begin
      rd   <= rd + 1'b1;
      fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/lacmd_decoder.sv
module lacmd_decoder
  import lacmd_pkg::*;
#(
  parameter int DIV_W  = 24,
  parameter int GROUPS = 4,
  parameter int GRP_CW = $clog2(GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              run_pulse,
  output logic              reset_pulse,
  output logic [DIV_W-1:0]  div_value,
  output logic [CNT_W:0]    read_count,
  output logic [CNT_W:0]    delay_count,
  output logic              demux_en,
  output logic              filter_en,
  output logic              rle_en,
  output logic [GROUPS-1:0] group_en,
  output logic [GRP_CW-1:0] groups_on,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready
);
  logic             frm_idle;
  logic             short_stb;
  logic [7:0]       short_code;
  logic             long_stb;
  logic [7:0]       long_op;
  logic [ARG_W-1:0] long_arg;
  logic [CNT_W-1:0] rd_field;
  logic [CNT_W-1:0] dl_field;
  logic [GROUPS+2:0] flags_q;
  logic             id_req;

  lacmd_frame u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_byte(rx_data),
    .idle(frm_idle), .short_stb(short_stb), .short_code(short_code),
    .long_stb(long_stb), .long_op(long_op), .long_arg(long_arg)
  );

  lacmd_regs #(.DIV_W(DIV_W), .GROUPS(GROUPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .long_stb(long_stb), .long_op(long_op),
    .long_arg(long_arg), .div_q(div_value), .rd_field(rd_field),
    .dl_field(dl_field), .flags_q(flags_q)
  );

  assign id_req = short_stb && (short_code == OP_ID);

  lacmd_reply #(.DEPTH(ID_LEN)) u_reply (
    .clk(clk), .rst_n(rst_n), .load(id_req), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign run_pulse   = short_stb && (short_code == OP_RUN);
  assign reset_pulse = short_stb && (short_code == OP_RESET);
  assign read_count  = count_of(rd_field);
  assign delay_count = count_of(dl_field);
  assign demux_en    = flags_q[0];
  assign filter_en   = flags_q[1];
  assign group_en    = ~flags_q[GROUPS+1:2];
  assign rle_en      = flags_q[GROUPS+2];
  assign groups_on   = GRP_CW'($countones(group_en));
endmodule

// File: rtl/lacmd_decoder_chk.sv
module lacmd_decoder_chk
  import lacmd_pkg::*;
#(
  parameter int DIV_W  = 24,
  parameter int GROUPS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              frm_idle,
  input logic              run_pulse,
  input logic              reset_pulse,
  input logic              long_stb,
  input logic [7:0]        long_op,
  input logic [DIV_W-1:0]  div_value,
  input logic [GROUPS+2:0] flags_q,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data
);
  logic [2:0] zrun;

  always_ff @(posedge clk) begin
    if (!rst_n) zrun <= '0;
    else if (rx_valid) begin
      if (rx_data != 8'h00) zrun <= '0;
      else if (zrun != 3'd7) zrun <= zrun + 1'b1;
    end
  end

  p_run_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |-> ($past(rx_valid) && $past(rx_data) == OP_RUN && $past(frm_idle)));

  p_reset_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> ($past(rx_valid) && $past(rx_data) == OP_RESET && $past(frm_idle)));

  p_zero_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zrun >= 3'd5) |-> frm_idle);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_div_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_value) |-> ($past(long_stb) && $past(long_op) == OP_DIV));

  p_flags_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags_q) |-> ($past(long_stb) && $past(long_op) == OP_FLAGS));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_pulse && reset_pulse));
endmodule

bind lacmd_decoder lacmd_decoder_chk #(.DIV_W(DIV_W), .GROUPS(GROUPS)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .frm_idle(frm_idle), .run_pulse(run_pulse), .reset_pulse(reset_pulse),
  .long_stb(long_stb), .long_op(long_op), .div_value(div_value),
  .flags_q(flags_q), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/lacmd_decoder_tb_top.sv
module lacmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_ready = 1'b0;
  logic        run_pulse, reset_pulse, demux_en, filter_en, rle_en, tx_valid;
  logic [23:0] div_value;
  logic [16:0] read_count, delay_count;
  logic [3:0]  group_en;
  logic [2:0]  groups_on;
  logic [7:0]  tx_data;

  int checks = 0;
  int fails = 0;
  int runs = 0;
  int resets = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lacmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .run_pulse(run_pulse), .reset_pulse(reset_pulse), .div_value(div_value),
    .read_count(read_count), .delay_count(delay_count), .demux_en(demux_en),
    .filter_en(filter_en), .rle_en(rle_en), .group_en(group_en),
    .groups_on(groups_on), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    if (run_pulse) runs++;
    if (reset_pulse) resets++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h00;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    send(op);
    for (int i = 0; i < 4; i++) send(arg[8*i +: 8]);
    repeat (2) @(negedge clk);
  endtask

  task automatic pop(input string req, input logic [7:0] exp);
    chk({req, " tx_valid"}, tx_valid, 1);
    chk({req, " tx_data"}, tx_data, exp);
    rx_valid = 1'b0;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, s0;
    logic [31:0] w;
    logic [15:0] lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 div", div_value, 0);
    chk("R1 read", read_count, 1);
    chk("R1 delay", delay_count, 1);
    chk("R1 groups", group_en, 4'hF);
    chk("R1 flags", {demux_en, filter_en, rle_en}, 0);
    chk("R1 on", groups_on, 4);
    chk("R1 tx", tx_valid, 0);

    // R3 divider sweep, byte 3 must be ignored
    for (int i = 0; i < 16; i++) begin
      w = (32'(i) * 32'h0013_5A7B) ^ 32'hA5C3_96E1 ^ (32'(i) << 20);
      send_long(8'h80, w);
      chk("R3 divider", div_value, w & 32'h00FF_FFFF);
    end

    // R4 capture size
    for (int i = 0; i < 8; i++) begin
      lo = 16'(i * 16'h2345) ^ 16'h0F0F;
      hi = 16'(i * 16'h1111) ^ 16'hF00F;
      if (i == 6) begin lo = 16'hFFFF; hi = 16'h0000; end
      if (i == 7) begin lo = 16'h0000; hi = 16'hFFFF; end
      send_long(8'h81, {hi, lo});
      chk("R4 read", read_count, 17'(lo) + 17'd1);
      chk("R4 delay", delay_count, 17'(hi) + 17'd1);
    end

    // R5 flags sweep over the low argument byte
    for (int v = 0; v < 256; v++) begin
      int on;
      send_long(8'h82, {24'hFFFFFF, 8'(v)});
      on = 0;
      for (int g = 0; g < 4; g++) if (((v >> (g + 2)) & 1) == 0) on++;
      chk("R5 demux", demux_en, v & 1);
      chk("R5 filter", filter_en, (v >> 1) & 1);
      chk("R5 rle", rle_en, (v >> 6) & 1);
      chk("R5 groups", group_en, (~(v >> 2)) & 4'hF);
      chk("R5 count", groups_on, on);
    end

    // R6 run strobe
    r0 = runs;
    send(8'h01);
    @(negedge clk);
    chk("R6 run count", runs - r0, 1);

    // R2 short codes inside a long command are arguments
    r0 = runs; s0 = resets;
    send_long(8'h80, 32'h0100_0201);
    chk("R2 div bytes", div_value, 24'h000201);
    chk("R2 no run", runs - r0, 0);
    chk("R2 no reset", resets - s0, 0);
    chk("R2 no reply", tx_valid, 0);

    // R10 unknown codes
    send_long(8'h82, 32'h0000_0015);
    send_long(8'h80, 32'h0012_3456);
    r0 = runs; s0 = resets;
    send(8'h05);
    send(8'h7F);
    send_long(8'hC3, 32'hFFFF_FFFF);
    chk("R10 div", div_value, 24'h123456);
    chk("R10 demux", demux_en, 1);
    chk("R10 groups", group_en, 4'hA);
    chk("R10 strobes", (runs - r0) + (resets - s0), 0);
    chk("R10 tx", tx_valid, 0);

    // R7 resync from every position of a long command
    for (int k = 0; k <= 4; k++) begin
      s0 = resets;
      send(8'h80);
      for (int j = 0; j < k; j++) send(8'hAA);
      for (int j = 0; j < 5; j++) send(8'h00);
      @(negedge clk);
      chk("R7 reset pulses", resets - s0, k + 1);
      send_long(8'h80, 32'h0056_3412);
      chk("R7 reframed", div_value, 24'h563412);
    end

    // R8 identification reply with back-pressure
    send(8'h02);
    repeat (3) @(negedge clk);
    pop("R8 b0", 8'h31);
    repeat (2) @(negedge clk);
    pop("R8 b1", 8'h53);
    pop("R8 b2", 8'h4C);
    pop("R8 b3", 8'h4F);
    chk("R8 empty", tx_valid, 0);

    // R9 second request while queue holds bytes
    send(8'h02);
    @(negedge clk);
    pop("R9 b0", 8'h31);
    send(8'h02);
    @(negedge clk);
    pop("R9 b1", 8'h53);
    pop("R9 b2", 8'h4C);
    pop("R9 b3", 8'h4F);
    chk("R9 dropped", tx_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule